// File: doc/BRIEF.md
# Saturating Integer Unit with Sticky Overflow Flag

This block is a single-cycle 32-bit integer datapath. It covers the arithmetic that clips rather than wraps. There are signed and unsigned saturating add and subtract. There is also an add that keeps the wrapped sum and only records signed overflow. Finally, it clamps a signed word, or each of its two signed halfwords, into a signed or unsigned range whose size is set by a 5-bit width operand `n`. A 4-bit opcode picks the operation, and the operands are presented together with a one-cycle strobe.

The outcome is written into a result register on the clock edge that samples the strobe. Every clipping event, and every overflow of the detect-only add, raises a sticky overflow flag. That flag is kept until a dedicated clear input or reset lowers it. If a clear and a raising event arrive in the same cycle, the flag stays raised. The result register keeps its value between strobes.

Top module: `satarith_unit`

## Requirements
- R1: Opcode 0 returns the wrapped sum a+b. It raises the flag when a and b share a sign bit and the sum's sign bit differs from a's.
- R2: Opcode 1 (a+b) and opcode 2 (a-b) return the exact signed result when it fits in 32 bits. Otherwise they return 0x80000000 when a is negative and 0x7FFFFFFF when it is not, and they raise the flag.
- R3: Opcode 3 returns a+b, or 0xFFFFFFFF with the flag raised when the unsigned sum exceeds 32 bits. Opcode 4 returns a-b, or 0 with the flag raised when b is larger than a as unsigned numbers.
- R4: Opcode 5 treats a as signed. It returns a when -2^n <= a <= 2^n-1. Otherwise it returns 2^n-1 for values above that range and -2^n for values below it, and raises the flag.
- R5: Opcode 6 treats a as signed. Negative values return 0 and values above 2^n-1 return 2^n-1, both raising the flag. Anything else passes unchanged.
- R6: Opcode 7 applies the R4 rule and opcode 8 applies the R5 rule to each sign-extended 16-bit half of a (bits 15:0 and bits 31:16) separately. Each half's low 16 bits are returned in its own position. The flag is raised if either half clips.
- R7: Opcodes 9 to 15 return 0 and never raise the flag.
- R8: The result and the flag change on the clock edge that samples the strobe. Without a strobe the result holds its value.
- R9: Once raised, the flag stays raised across any number of operations while clear is low.
- R10: Clear lowers the flag on the next edge unless a raising event is sampled on the same edge, in which case the flag stays raised.
- R11: While reset is asserted the result is 0 and the flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| i_valid | input | 1 | Operation strobe |
| i_op | input | 4 | Operation code |
| i_a | input | 32 | First operand; value to clamp for opcodes 5 to 8 |
| i_b | input | 32 | Second operand |
| i_width | input | 5 | Clamp width n, 0 to 31 |
| i_flag_clr | input | 1 | Clears the sticky flag |
| o_result | output | 32 | Registered result |
| o_sat_flag | output | 1 | Sticky overflow flag |

## Verification
A wrong limit or a wrong detection term in any lane is visible on `o_result` and `o_sat_flag` at the first edge after the strobe. The most likely wrong values are at the range edges: 2^n-1 against 2^n, -2^n against -2^n-1, and operand pairs whose signs straddle zero. The sweeps therefore place operands on both sides of every boundary, for every n. The sticky state can only go wrong by rising without cause or falling without a clear. Because every vector is issued together with a clear, each flag reading shows that vector's own event one edge later.

// File: rtl/satarith_pkg.sv
package satarith_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD_WRAP = 4'd0,
    OP_ADD_SS   = 4'd1,
    OP_SUB_SS   = 4'd2,
    OP_ADD_US   = 4'd3,
    OP_SUB_US   = 4'd4,
    OP_CLAMP_S  = 4'd5,
    OP_CLAMP_U  = 4'd6,
    OP_CLAMP_S2 = 4'd7,
    OP_CLAMP_U2 = 4'd8
  } sat_op_e;
endpackage

// File: rtl/satarith_addsub.sv
module satarith_addsub
  import satarith_pkg::*;
#(
  parameter int W = 32
) (
  input  sat_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   res,
  output logic           ovf
);
  // Signed overflow: sign of result disagrees with a, given the operand sign relation
  function automatic logic signed_ovf(logic [W-1:0] x, logic [W-1:0] y,
                                      logic [W-1:0] r, logic is_sub);
    logic same_sign;
    same_sign = (x[W-1] == y[W-1]);
    return (is_sub ? !same_sign : same_sign) && (r[W-1] != x[W-1]);
  endfunction

  // Signed clip value chosen by the sign of the first operand
  function automatic logic [W-1:0] signed_limit(logic neg);
    return {neg, {(W-1){~neg}}};
  endfunction

  logic [W-1:0] sum_w;
  logic [W-1:0] dif_w;
  logic         add_sov;
  logic         sub_sov;

  assign sum_w   = a + b;
  assign dif_w   = a - b;
  assign add_sov = signed_ovf(a, b, sum_w, 1'b0);
  assign sub_sov = signed_ovf(a, b, dif_w, 1'b1);

  always_comb begin
    res = '0;
    ovf = 1'b0;
    unique case (op)
      OP_ADD_WRAP: begin
        res = sum_w;
        ovf = add_sov;
      end
      OP_ADD_SS: begin
        res = add_sov ? signed_limit(a[W-1]) : sum_w;
        ovf = add_sov;
      end
      OP_SUB_SS: begin
        res = sub_sov ? signed_limit(a[W-1]) : dif_w;
        ovf = sub_sov;
      end
      OP_ADD_US: begin
        ovf = (sum_w < a);
        res = ovf ? {W{1'b1}} : sum_w;
      end
      OP_SUB_US: begin
        ovf = (dif_w > a);
        res = ovf ? '0 : dif_w;
      end
      default: begin
        res = '0;
        ovf = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/satarith_clamp.sv
module satarith_clamp #(
  parameter int W  = 32,
  parameter int NW = $clog2(W)
) (
  input  logic [W-1:0]  val,
  input  logic [NW-1:0] n,
  input  logic          is_unsigned,
  output logic [W-1:0]  res,
  output logic          ovf
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  function automatic logic [W-1:0] range_mask(logic [NW-1:0] k);
    return (ONE << k) - ONE;
  endfunction

  logic [W-1:0]        mask;
  logic signed [W-1:0] top;
  logic                s_hi;
  logic                s_lo;
  logic                u_neg;
  logic                u_hi;

  assign mask  = range_mask(n);
  assign top   = $signed(val) >>> n;
  assign s_hi  = (top > $signed({W{1'b0}}));
  assign s_lo  = (top < $signed({W{1'b1}}));
  assign u_neg = val[W-1];
  assign u_hi  = !u_neg && (val > mask);

  always_comb begin
    if (is_unsigned) begin
      ovf = u_neg || u_hi;
      res = u_neg ? '0 : (u_hi ? mask : val);
    end else begin
      ovf = s_hi || s_lo;
      res = s_hi ? mask : (s_lo ? ~mask : val);
    end
  end
endmodule

// File: rtl/satarith_sticky.sv
module satarith_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/satarith_unit.sv
module satarith_unit
  import satarith_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NW     = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_valid,
  input  logic [OP_W-1:0]   i_op,
  input  logic [DATA_W-1:0] i_a,
  input  logic [DATA_W-1:0] i_b,
  input  logic [NW-1:0]     i_width,
  input  logic              i_flag_clr,
  output logic [DATA_W-1:0] o_result,
  output logic              o_sat_flag
);
  localparam int HW    = DATA_W / 2;
  localparam int NHALF = 2;

  sat_op_e op;
  assign op = sat_op_e'(i_op);

  // add/sub lane
  logic [DATA_W-1:0] as_res;
  logic              as_ovf;

  satarith_addsub #(.W(DATA_W)) u_addsub (
    .op  (op),
    .a   (i_a),
    .b   (i_b),
    .res (as_res),
    .ovf (as_ovf)
  );

  // full-word clamp lane
  logic [DATA_W-1:0] wc_res;
  logic              wc_ovf;

  satarith_clamp #(.W(DATA_W), .NW(NW)) u_clamp_word (
    .val         (i_a),
    .n           (i_width),
    .is_unsigned (op == OP_CLAMP_U),
    .res         (wc_res),
    .ovf         (wc_ovf)
  );

  // halfword clamp lanes
  logic [DATA_W-1:0] hc_res [NHALF];
  logic [NHALF-1:0]  hc_ovf;
  logic [DATA_W-1:0] hc_packed;

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    logic [DATA_W-1:0] half_ext;
    assign half_ext = {{(DATA_W-HW){i_a[h*HW+HW-1]}}, i_a[h*HW +: HW]};

    satarith_clamp #(.W(DATA_W), .NW(NW)) u_clamp_half (
      .val         (half_ext),
      .n           (i_width),
      .is_unsigned (op == OP_CLAMP_U2),
      .res         (hc_res[h]),
      .ovf         (hc_ovf[h])
    );
    assign hc_packed[h*HW +: HW] = hc_res[h][HW-1:0];
  end

  // operation select
  logic [DATA_W-1:0] next_res;
  logic              sat_event;

  always_comb begin
    next_res  = '0;
    sat_event = 1'b0;
    unique case (op)
      OP_ADD_WRAP, OP_ADD_SS, OP_SUB_SS, OP_ADD_US, OP_SUB_US: begin
        next_res  = as_res;
        sat_event = as_ovf;
      end
      OP_CLAMP_S, OP_CLAMP_U: begin
        next_res  = wc_res;
        sat_event = wc_ovf;
      end
      OP_CLAMP_S2, OP_CLAMP_U2: begin
        next_res  = hc_packed;
        sat_event = |hc_ovf;
      end
      default: begin
        next_res  = '0;
        sat_event = 1'b0;
      end
    endcase
  end

  logic flag_set;
  assign flag_set = i_valid && sat_event;

  always_ff @(posedge clk) begin
    if (!rst_n)       o_result <= '0;
    else if (i_valid) o_result <= next_res;
  end

  satarith_sticky u_sticky (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (flag_set),
    .clr   (i_flag_clr),
    .flag  (o_sat_flag)
  );
endmodule

// File: rtl/satarith_chk.sv
module satarith_chk
  import satarith_pkg::*;
#(
  parameter int W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            i_valid,
  input logic [OP_W-1:0] i_op,
  input logic [W-1:0]    i_a,
  input logic [W-1:0]    i_b,
  input logic            i_flag_clr,
  input logic [W-1:0]    o_result,
  input logic            o_sat_flag,
  input logic            sat_event
);
  // R1: wrapped sum lands one edge after the strobe
  p_wrap_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (i_valid && i_op == OP_ADD_WRAP) |=> (o_result == $past(i_a + i_b)));

  // R3: unsigned saturating add never falls below a
  p_uadd_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (i_valid && i_op == OP_ADD_US) |=> (o_result >= $past(i_a)));

  // R3: unsigned saturating subtract never exceeds a
  p_usub_ceil_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (i_valid && i_op == OP_SUB_US) |=> (o_result <= $past(i_a)));

  // R7: reserved codes produce zero and no event
  p_reserved_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (i_valid && i_op > OP_CLAMP_U2) |=> (o_result == '0));

  // R8: result holds without a strobe
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !i_valid |=> $stable(o_result));

  // R9: flag stays up while clear is low
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (o_sat_flag && !i_flag_clr) |=> o_sat_flag);

  // R9: flag only rises after a sampled event
  p_rise_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(o_sat_flag) |-> $past(i_valid && sat_event));

  // R10: an event beats a simultaneous clear
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (i_valid && sat_event) |=> o_sat_flag);

  // R10: clear without event lowers the flag
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (i_flag_clr && !(i_valid && sat_event)) |=> !o_sat_flag);

  // R11: reset values
  p_reset_r11: assert property (@(posedge clk)
    !rst_n |=> (o_result == '0 && !o_sat_flag));
endmodule

bind satarith_unit satarith_chk #(.W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .i_valid    (i_valid),
  .i_op       (i_op),
  .i_a        (i_a),
  .i_b        (i_b),
  .i_flag_clr (i_flag_clr),
  .o_result   (o_result),
  .o_sat_flag (o_sat_flag),
  .sat_event  (sat_event)
);

// File: tb/satarith_unit_tb.sv
module satarith_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        i_valid = 1'b0;
  logic [3:0]  i_op = '0;
  logic [31:0] i_a = '0;
  logic [31:0] i_b = '0;
  logic [4:0]  i_width = '0;
  logic        i_flag_clr = 1'b0;
  logic [31:0] o_result;
  logic        o_sat_flag;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  satarith_unit u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .i_valid    (i_valid),
    .i_op       (i_op),
    .i_a        (i_a),
    .i_b        (i_b),
    .i_width    (i_width),
    .i_flag_clr (i_flag_clr),
    .o_result   (o_result),
    .o_sat_flag (o_sat_flag)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h (op %0d a %08h b %08h n %0d)",
               tag, got, exp, i_op, i_a, i_b, i_width);
    end
  endtask

  // clip v into [lo,hi]
  function automatic void lim(input longint v, input longint lo, input longint hi,
                              output longint o, output bit e);
    e = 1'b0;
    o = v;
    if (v > hi) begin o = hi; e = 1'b1; end
    else if (v < lo) begin o = lo; e = 1'b1; end
  endfunction

  function automatic void ref_calc(input int op, input logic [31:0] a, input logic [31:0] b,
                                   input int n, output logic [31:0] r, output bit ev);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint ua = longint'({32'b0, a});
    longint ub = longint'({32'b0, b});
    longint smax = (64'sd1 <<< 31) - 1;
    longint smin = -(64'sd1 <<< 31);
    longint top = (64'sd1 <<< n) - 1;
    longint t, o;
    bit e0, e1;
    r = '0;
    ev = 1'b0;
    case (op)
      0: begin t = sa + sb; r = t[31:0]; ev = (t > smax) || (t < smin); end
      1: begin lim(sa + sb, smin, smax, o, ev); r = o[31:0]; end
      2: begin lim(sa - sb, smin, smax, o, ev); r = o[31:0]; end
      3: begin lim(ua + ub, 0, 64'hFFFF_FFFF, o, ev); r = o[31:0]; end
      4: begin lim(ua - ub, 0, 64'hFFFF_FFFF, o, ev); r = o[31:0]; end
      5: begin lim(sa, -top - 1, top, o, ev); r = o[31:0]; end
      6: begin lim(sa, 0, top, o, ev); r = o[31:0]; end
      7, 8: begin
        longint h0 = longint'($signed(a[15:0]));
        longint h1 = longint'($signed(a[31:16]));
        longint lo = (op == 7) ? -top - 1 : 0;
        longint o1;
        lim(h0, lo, top, o, e0);
        lim(h1, lo, top, o1, e1);
        r = {o1[15:0], o[15:0]};
        ev = e0 | e1;
      end
      default: begin r = '0; ev = 1'b0; end
    endcase
  endfunction

  function automatic string tag_of(int op);
    case (op)
      0: return "R1";
      1, 2: return "R2";
      3, 4: return "R3";
      5: return "R4";
      6: return "R5";
      7, 8: return "R6";
      default: return "R7";
    endcase
  endfunction

  // one vector issued with clear high: flag afterwards equals this vector's event (R10)
  task automatic run_vec(int op, logic [31:0] a, logic [31:0] b, int n);
    logic [31:0] er;
    bit ee;
    ref_calc(op, a, b, n, er, ee);
    @(negedge clk);
    i_op = op[3:0]; i_a = a; i_b = b; i_width = n[4:0];
    i_valid = 1'b1; i_flag_clr = 1'b1;
    @(negedge clk);
    i_valid = 1'b0; i_flag_clr = 1'b0;
    check(tag_of(op), o_result, er);
    check("R10", {31'b0, o_sat_flag}, {31'b0, ee});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] corners [10];
    logic [31:0] held;
    corners = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000,
                32'h7FFF_FFFE, 32'h8000_0001, 32'h4000_0000, 32'hC000_0000, 32'h1234_5678};

    // R11: reset state
    repeat (3) @(negedge clk);
    check("R11", o_result, 32'h0);
    check("R11", {31'b0, o_sat_flag}, 32'h0);
    rst_n = 1'b1;

    // R1..R3: operand corner sweep
    for (int op = 0; op <= 4; op++)
      for (int i = 0; i < 10; i++)
        for (int j = 0; j < 10; j++)
          run_vec(op, corners[i], corners[j], 0);

    // R4..R6: every width, values straddling each boundary
    for (int n = 0; n < 32; n++) begin
      logic [31:0] pts [8];
      logic [31:0] p = 32'h1 << n;
      pts = '{p - 1, p, -p, -p - 1, 32'h0, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000};
      for (int i = 0; i < 8; i++) begin
        run_vec(5, pts[i], 32'h0, n);
        run_vec(6, pts[i], 32'h0, n);
      end
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++) begin
          logic [31:0] v = {pts[i][15:0], pts[j][15:0]};
          run_vec(7, v, 32'h0, n);
          run_vec(8, v, 32'h0, n);
        end
    end

    // R7: reserved codes
    for (int op = 9; op < 16; op++)
      run_vec(op, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 3);

    // R8: hold without strobe
    run_vec(1, 32'h0000_0005, 32'h0000_0007, 0);
    held = o_result;
    @(negedge clk);
    i_op = 4'd0; i_a = 32'hDEAD_BEEF; i_b = 32'h1111_1111;
    repeat (3) @(negedge clk);
    check("R8", o_result, held);

    // R9: sticky across non-saturating ops
    run_vec(3, 32'hFFFF_FFFF, 32'h2, 0);
    check("R9", {31'b0, o_sat_flag}, 32'h1);
    @(negedge clk);
    i_op = 4'd0; i_a = 32'h1; i_b = 32'h2; i_valid = 1'b1;
    @(negedge clk);
    i_op = 4'd4; i_a = 32'h9; i_b = 32'h4;
    @(negedge clk);
    i_valid = 1'b0;
    check("R9", o_result, 32'h5);
    check("R9", {31'b0, o_sat_flag}, 32'h1);

    // R10: lone clear lowers the flag
    i_flag_clr = 1'b1;
    @(negedge clk);
    i_flag_clr = 1'b0;
    check("R10", {31'b0, o_sat_flag}, 32'h0);

    // R11: reset mid-run
    run_vec(2, 32'h8000_0000, 32'h1, 0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R11", o_result, 32'h0);
    check("R11", {31'b0, o_sat_flag}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule